// File: doc/BRIEF.md
# Teletext Page Request Matcher

This block watches the stream of decoded teletext page headers and decides which of four page-request slots, if any, wants each page. Every slot stores seven 5-bit request entries. Each entry has a care flag. A slot therefore selects one page, a whole magazine, or a single timed subpage, according to which digits the controller marks as significant. The header digits arrive already Hamming-decoded, each with its own error flag. A one-cycle strobe marks them valid.

When a header is accepted, a two-state controller moves from `S_IDLE` to `S_CMP`. It stays in `S_CMP` while strobes keep arriving and returns to `S_IDLE` on the first cycle without one. In `S_CMP` the slot comparators run, and the per-slot result is registered as a one-clock match pulse. The lowest-numbered matching slot wins the status row. That row is ten bytes of page information for row 25, read back through a byte-index port. It includes a found flag and a searching flag. Requests are loaded through a small write port. A column write chooses the slot, its memory bank bit and a start column. Data writes then fill the entries and step the column automatically.

Top module: `tpm_matcher`

## Requirements
- R1: After reset no match pulse is driven and `match_chap` is 0. Status byte 8 reads 0x10 and bytes 0..7 and 9 read 0x00. All request entries are zero, so no slot can match.
- R2: A `cfg_wr` latches the target slot, stores `cfg_bank` as that slot's bank bit, and sets the column pointer to `cfg_col` (a value of 7 selects column 0). Each `dat_wr` writes `dat` into the pointed entry of the latched slot and advances the pointer. After column 6 the pointer wraps to column 0.
- R3: The column order is 0 magazine, 1 page tens, 2 page units, 3 hours tens, 4 hours units, 5 minutes tens, 6 minutes units. Bit 4 of an entry is its care flag. A cared entry must equal the header digit for the slot to match. The compared widths are 3 bits for the magazine (entry bits 2..0), 2 bits for hours tens, 3 bits for minutes tens and 4 bits for the rest.
- R4: Bit 3 of the magazine entry is the HOLD bit. While it is 0 the slot never matches, whatever the header holds.
- R5: An entry whose care flag is 0 never blocks a match, so one request can accept every subpage or only one time code.
- R6: Header error flags use bits 0 PU, 1 PT, 2 MU, 3 MT, 4 HU, 5 HT, 6 C7..C10, 7 C11..C14 and 8 magazine. An error on the magazine, page tens or page units blocks every slot. An error on a time digit blocks only the slots that care about that digit.
- R7: A header strobed at clock edge k gives its match pulse in the cycle after edge k+1, one clock wide. Headers strobed in consecutive cycles each get their own pulse in consecutive cycles.
- R8: When any slot matches, `match_chap` takes the value {bank bit, slot index} of the lowest-numbered matching slot. It holds that value until the next match.
- R9: A matching header is captured into the status row, and a header that matches no slot leaves the row unchanged. Each of bytes 0..7 has bits 7..5 = 0 and the digit's error flag in bit 4. The low bits are, byte by byte: 0 PU, 1 PT, 2 MU, 3 {C4, MT}, 4 HU, 5 {C6, C5, HT}, 6 C10..C7, 7 C14..C11.
- R10: Status byte 8 holds the magazine in bits 2..0 and an active-low found flag in bit 4. The found flag goes to 0 on the first capture. Byte 9 bit 5 is set by every `dat_wr` and cleared by a capture, and a `dat_wr` in the same cycle as a capture leaves it set. Byte indices 10..15 read 0.
- R11: A request write that lands on the same clock edge as a comparison does not affect that comparison. The comparison uses the entries as they were before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Column/slot write strobe |
| cfg_slot | input | 2 | Slot to load |
| cfg_bank | input | 1 | Memory bank bit for that slot |
| cfg_col | input | 3 | Start column |
| dat_wr | input | 1 | Request entry write strobe |
| dat | input | 5 | Entry value: care bit 4, digit bits 3..0 |
| hdr_valid | input | 1 | Header strobe |
| hdr_mag | input | 3 | Magazine number |
| hdr_pt | input | 4 | Page tens |
| hdr_pu | input | 4 | Page units |
| hdr_ht | input | 2 | Hours tens |
| hdr_hu | input | 4 | Hours units |
| hdr_mt | input | 3 | Minutes tens |
| hdr_mu | input | 4 | Minutes units |
| hdr_ctl | input | 11 | Control bits C14..C4 (bit 0 is C4) |
| hdr_err | input | 9 | Per-digit Hamming error flags |
| match_pulse | output | 4 | One-clock match per slot |
| match_chap | output | 3 | {bank, slot} of the winning slot |
| sr_idx | input | 4 | Status row byte index |
| sr_byte | output | 8 | Status row byte |

## Verification
Two pairs of functions can meet on one clock edge, and both are tested. In the first, a request data write is issued in the cycle after a header strobe, so it lands on the comparison edge. The bench expects the match that the old entry value gives, and it checks the new value with later headers. That same edge also carries a capture, so it tests the searching flag as well: a write and a capture together must leave byte 9 at 0x20. Back-to-back header strobes are also judged, by requiring two distinct pulses in consecutive cycles.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    localparam int NUM_COLS = 7;
    localparam int ENT_W    = 5;
    localparam int DIG_W    = 4;
    localparam int CARE_BIT = 4;
    localparam int HOLD_BIT = 3;
    localparam int ERR_W    = 9;
    localparam int CTL_W    = 11;
    localparam int SR_IDX_W = 4;

    localparam int COL_MAG = 0;
    localparam int COL_PT  = 1;
    localparam int COL_PU  = 2;
    localparam int COL_HT  = 3;
    localparam int COL_HU  = 4;
    localparam int COL_MT  = 5;
    localparam int COL_MU  = 6;

    localparam int ERR_PU  = 0;
    localparam int ERR_PT  = 1;
    localparam int ERR_MU  = 2;
    localparam int ERR_MT  = 3;
    localparam int ERR_HU  = 4;
    localparam int ERR_HT  = 5;
    localparam int ERR_CA  = 6;
    localparam int ERR_CB  = 7;
    localparam int ERR_MAG = 8;

    // significant digit bits per column, column 6 first
    localparam logic [NUM_COLS-1:0][DIG_W-1:0] COL_MASK =
        {4'hF, 4'h7, 4'hF, 4'h3, 4'hF, 4'hF, 4'h7};

    typedef struct packed {
        logic [2:0]       mag;
        logic [3:0]       pt;
        logic [3:0]       pu;
        logic [1:0]       ht;
        logic [3:0]       hu;
        logic [2:0]       mt;
        logic [3:0]       mu;
        logic [CTL_W-1:0] ctl;
        logic [ERR_W-1:0] err;
    } hdr_t;

    typedef enum logic [0:0] {S_IDLE, S_CMP} state_t;
endpackage

// File: rtl/tpm_req_store.sv
module tpm_req_store
    import tpm_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cfg_wr,
    input  logic [SLOT_W-1:0]                             cfg_slot,
    input  logic                                          cfg_bank,
    input  logic [2:0]                                    cfg_col,
    input  logic                                          dat_wr,
    input  logic [ENT_W-1:0]                              dat,
    output logic [NUM_SLOTS-1:0][NUM_COLS-1:0][ENT_W-1:0] ent,
    output logic [NUM_SLOTS-1:0]                          bank
);
    localparam logic [2:0] LAST_COL = 3'(NUM_COLS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [2:0]        col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent    <= '0;
            bank   <= '0;
            slot_q <= '0;
            col_q  <= '0;
        end else if (cfg_wr) begin
            slot_q         <= cfg_slot;
            bank[cfg_slot] <= cfg_bank;
            col_q          <= (cfg_col > LAST_COL) ? 3'd0 : cfg_col;
        end else if (dat_wr) begin
            ent[slot_q][col_q] <= dat;
            col_q              <= (col_q == LAST_COL) ? 3'd0 : col_q + 3'd1;
        end
    end

    a_r2_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= LAST_COL);
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !cfg_wr && col_q != LAST_COL) |=> (col_q == $past(col_q) + 3'd1));
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !cfg_wr && col_q == LAST_COL) |=> (col_q == 3'd0));
endmodule

// File: rtl/tpm_slot_cmp.sv
module tpm_slot_cmp
    import tpm_pkg::*;
(
    input  logic [NUM_COLS-1:0][ENT_W-1:0] ent,
    input  hdr_t                           hdr,
    output logic                           hit
);
    logic [NUM_COLS-1:0][DIG_W-1:0] dig;
    logic [NUM_COLS-1:0]            derr;
    logic [NUM_COLS-1:0]            ok;
    logic                           page_err;

    always_comb begin
        dig[COL_MAG] = {1'b0, hdr.mag};
        dig[COL_PT]  = hdr.pt;
        dig[COL_PU]  = hdr.pu;
        dig[COL_HT]  = {2'b00, hdr.ht};
        dig[COL_HU]  = hdr.hu;
        dig[COL_MT]  = {1'b0, hdr.mt};
        dig[COL_MU]  = hdr.mu;

        derr[COL_MAG] = hdr.err[ERR_MAG];
        derr[COL_PT]  = hdr.err[ERR_PT];
        derr[COL_PU]  = hdr.err[ERR_PU];
        derr[COL_HT]  = hdr.err[ERR_HT];
        derr[COL_HU]  = hdr.err[ERR_HU];
        derr[COL_MT]  = hdr.err[ERR_MT];
        derr[COL_MU]  = hdr.err[ERR_MU];

        for (int c = 0; c < NUM_COLS; c++) begin
            ok[c] = !ent[c][CARE_BIT] ||
                    (!derr[c] && (((ent[c][DIG_W-1:0] ^ dig[c]) & COL_MASK[c]) == '0));
        end

        page_err = hdr.err[ERR_MAG] || hdr.err[ERR_PT] || hdr.err[ERR_PU];
        hit      = ent[COL_MAG][HOLD_BIT] && !page_err && (&ok);
    end
endmodule

// File: rtl/tpm_status_row.sv
module tpm_status_row
    import tpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  hdr_t                cap_hdr,
    input  logic                req_wr,
    input  logic [SR_IDX_W-1:0] sr_idx,
    output logic [7:0]          sr_byte
);
    hdr_t row_q;
    logic found_n_q;
    logic pblf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q     <= '0;
            found_n_q <= 1'b1;
            pblf_q    <= 1'b0;
        end else begin
            if (cap_en) begin
                row_q     <= cap_hdr;
                found_n_q <= 1'b0;
            end
            if (req_wr)      pblf_q <= 1'b1;
            else if (cap_en) pblf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sr_idx)
            4'd0:    sr_byte = {3'b000, row_q.err[ERR_PU], row_q.pu};
            4'd1:    sr_byte = {3'b000, row_q.err[ERR_PT], row_q.pt};
            4'd2:    sr_byte = {3'b000, row_q.err[ERR_MU], row_q.mu};
            4'd3:    sr_byte = {3'b000, row_q.err[ERR_MT], row_q.ctl[0], row_q.mt};
            4'd4:    sr_byte = {3'b000, row_q.err[ERR_HU], row_q.hu};
            4'd5:    sr_byte = {3'b000, row_q.err[ERR_HT], row_q.ctl[2:1], row_q.ht};
            4'd6:    sr_byte = {3'b000, row_q.err[ERR_CA], row_q.ctl[6:3]};
            4'd7:    sr_byte = {3'b000, row_q.err[ERR_CB], row_q.ctl[10:7]};
            4'd8:    sr_byte = {3'b000, found_n_q, 1'b0, row_q.mag};
            4'd9:    sr_byte = {2'b00, pblf_q, 5'b00000};
            default: sr_byte = 8'h00;
        endcase
    end

    a_r10_found_low: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> !found_n_q);
    a_r10_pblf_set: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> pblf_q);
    a_r10_pblf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !req_wr) |=> !pblf_q);
endmodule

// File: rtl/tpm_matcher.sv
module tpm_matcher
    import tpm_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic                 cfg_bank,
    input  logic [2:0]           cfg_col,
    input  logic                 dat_wr,
    input  logic [ENT_W-1:0]     dat,
    input  logic                 hdr_valid,
    input  logic [2:0]           hdr_mag,
    input  logic [3:0]           hdr_pt,
    input  logic [3:0]           hdr_pu,
    input  logic [1:0]           hdr_ht,
    input  logic [3:0]           hdr_hu,
    input  logic [2:0]           hdr_mt,
    input  logic [3:0]           hdr_mu,
    input  logic [CTL_W-1:0]     hdr_ctl,
    input  logic [ERR_W-1:0]     hdr_err,
    output logic [NUM_SLOTS-1:0] match_pulse,
    output logic [SLOT_W:0]      match_chap,
    input  logic [SR_IDX_W-1:0]  sr_idx,
    output logic [7:0]           sr_byte
);
    state_t state_q, state_d;
    hdr_t   hdr_in, hdr_q;

    logic [NUM_SLOTS-1:0][NUM_COLS-1:0][ENT_W-1:0] ent;
    logic [NUM_SLOTS-1:0] bank;
    logic [NUM_SLOTS-1:0] hits;
    logic [SLOT_W-1:0]    win_idx;
    logic                 cap_en;

    always_comb begin
        hdr_in.mag = hdr_mag;
        hdr_in.pt  = hdr_pt;
        hdr_in.pu  = hdr_pu;
        hdr_in.ht  = hdr_ht;
        hdr_in.hu  = hdr_hu;
        hdr_in.mt  = hdr_mt;
        hdr_in.mu  = hdr_mu;
        hdr_in.ctl = hdr_ctl;
        hdr_in.err = hdr_err;
    end

    tpm_req_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_slot(cfg_slot), .cfg_bank(cfg_bank), .cfg_col(cfg_col),
        .dat_wr(dat_wr), .dat(dat),
        .ent(ent), .bank(bank)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        tpm_slot_cmp u_cmp (.ent(ent[s]), .hdr(hdr_q), .hit(hits[s]));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = hdr_valid ? S_CMP : S_IDLE;
            S_CMP:   state_d = hdr_valid ? S_CMP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         hdr_q <= '0;
        else if (hdr_valid) hdr_q <= hdr_in;
    end

    always_comb begin
        win_idx = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (hits[s]) win_idx = SLOT_W'(s);
        end
    end

    assign cap_en = (state_q == S_CMP) && (|hits);

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_pulse <= '0;
            match_chap  <= '0;
        end else begin
            match_pulse <= (state_q == S_CMP) ? hits : '0;
            if (cap_en) match_chap <= {bank[win_idx], win_idx};
        end
    end

    tpm_status_row u_row (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_hdr(hdr_q),
        .req_wr(dat_wr), .sr_idx(sr_idx), .sr_byte(sr_byte)
    );

    a_r7_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> (match_pulse == '0));
    a_r6_page_err_block: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMP && (hdr_q.err[ERR_MAG] || hdr_q.err[ERR_PT] || hdr_q.err[ERR_PU]))
        |=> (match_pulse == '0));
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse[0] |-> (match_chap[SLOT_W-1:0] == '0));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hold_chk
        a_r4_held_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == S_CMP && !ent[s][COL_MAG][HOLD_BIT]) |=> !match_pulse[s]);
    end
endmodule

// File: tb/tpm_matcher_bench.sv
module tpm_matcher_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_slot = '0;
    logic       cfg_bank = 1'b0;
    logic [2:0] cfg_col = '0;
    logic       dat_wr = 1'b0;
    logic [4:0] dat = '0;
    logic       hdr_valid = 1'b0;
    logic [2:0] hdr_mag = '0;
    logic [3:0] hdr_pt = '0, hdr_pu = '0, hdr_hu = '0, hdr_mu = '0;
    logic [1:0] hdr_ht = '0;
    logic [2:0] hdr_mt = '0;
    logic [10:0] hdr_ctl = '0;
    logic [8:0]  hdr_err = '0;
    logic [3:0]  match_pulse;
    logic [2:0]  match_chap;
    logic [3:0]  sr_idx = '0;
    logic [7:0]  sr_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpm_matcher u_tpm_matcher (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_slot(cfg_slot), .cfg_bank(cfg_bank), .cfg_col(cfg_col),
        .dat_wr(dat_wr), .dat(dat),
        .hdr_valid(hdr_valid), .hdr_mag(hdr_mag), .hdr_pt(hdr_pt), .hdr_pu(hdr_pu),
        .hdr_ht(hdr_ht), .hdr_hu(hdr_hu), .hdr_mt(hdr_mt), .hdr_mu(hdr_mu),
        .hdr_ctl(hdr_ctl), .hdr_err(hdr_err),
        .match_pulse(match_pulse), .match_chap(match_chap),
        .sr_idx(sr_idx), .sr_byte(sr_byte)
    );

    // {chap[39:37], mask[36:33], err[32:24], mag[23:21], pt[20:17], pu[16:13], ht[12:11], hu[10:7], mt[6:4], mu[3:0]}
    localparam int NVEC = 9;
    localparam logic [39:0] VEC [NVEC] = '{
        {3'd0, 4'b0011, 9'h000, 3'd1, 4'd2, 4'd3, 2'd0, 4'd0, 3'd0, 4'd5},
        {3'd0, 4'b0001, 9'h000, 3'd1, 4'd2, 4'd3, 2'd0, 4'd0, 3'd0, 4'd4},
        {3'd2, 4'b0100, 9'h000, 3'd4, 4'd9, 4'd9, 2'd0, 4'd0, 3'd0, 4'd0},
        {3'd0, 4'b0000, 9'h000, 3'd1, 4'd2, 4'd4, 2'd0, 4'd0, 3'd0, 4'd5},
        {3'd0, 4'b0000, 9'h001, 3'd1, 4'd2, 4'd3, 2'd0, 4'd0, 3'd0, 4'd5},
        {3'd0, 4'b0000, 9'h002, 3'd4, 4'd0, 4'd0, 2'd0, 4'd0, 3'd0, 4'd0},
        {3'd0, 4'b0001, 9'h004, 3'd1, 4'd2, 4'd3, 2'd0, 4'd0, 3'd0, 4'd5},
        {3'd0, 4'b0000, 9'h000, 3'd2, 4'd2, 4'd3, 2'd0, 4'd0, 3'd0, 4'd5},
        {3'd0, 4'b0000, 9'h100, 3'd4, 4'd1, 4'd1, 2'd0, 4'd0, 3'd0, 4'd0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] slot, input logic bank, input logic [2:0] col);
        cfg_wr = 1'b1; cfg_slot = slot; cfg_bank = bank; cfg_col = col;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr(input logic [4:0] v);
        dat_wr = 1'b1; dat = v;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic set_hdr(input logic [23:0] f, input logic [8:0] e, input logic [10:0] c);
        {hdr_mag, hdr_pt, hdr_pu, hdr_ht, hdr_hu, hdr_mt, hdr_mu} = f;
        hdr_err = e; hdr_ctl = c;
    endtask

    task automatic run_hdr(input string tag, input logic [23:0] f, input logic [8:0] e,
                           input logic [3:0] exp_mask, input bit chk_chap, input logic [2:0] exp_chap);
        set_hdr(f, e, 11'd0);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        @(negedge clk);
        chk(tag, 16'(match_pulse), 16'(exp_mask));
        if (chk_chap) chk({tag, " R8 chap"}, 16'(match_chap), 16'(exp_chap));
        @(negedge clk);
        chk("R7 pulse one clock", 16'(match_pulse), 16'h0);
    endtask

    task automatic rd(input string tag, input logic [3:0] idx, input logic [7:0] exp);
        sr_idx = idx;
        #1;
        chk(tag, 16'(sr_byte), 16'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [10:0] c;
        logic [8:0]  e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pulse", 16'(match_pulse), 16'h0);
        chk("R1 chap", 16'(match_chap), 16'h0);
        rd("R1 byte8", 4'd8, 8'h10);
        rd("R1 byte9", 4'd9, 8'h00);
        rd("R1 byte0", 4'd0, 8'h00);
        run_hdr("R1 reset slots held", 24'h0, 9'h0, 4'b0000, 1'b0, 3'd0);

        // load requests (R2)
        cfg(2'd0, 1'b0, 3'd0);
        wr(5'h19); wr(5'h12); wr(5'h13); wr(5'h00); wr(5'h00); wr(5'h00); wr(5'h00);
        cfg(2'd1, 1'b1, 3'd0);
        wr(5'h19); wr(5'h12); wr(5'h13); wr(5'h00); wr(5'h00); wr(5'h00); wr(5'h15);
        cfg(2'd2, 1'b0, 3'd0);
        wr(5'h1C);
        cfg(2'd3, 1'b1, 3'd0);
        wr(5'h11); wr(5'h12); wr(5'h13);
        rd("R10 searching after writes", 4'd9, 8'h20);
        rd("R10 not found yet", 4'd8, 8'h10);

        // table: R3 R5 R6 R4
        for (int i = 0; i < NVEC; i++) begin
            run_hdr("R3/R5/R6 table", VEC[i][23:0], VEC[i][32:24], VEC[i][36:33],
                    VEC[i][36:33] != 4'b0, VEC[i][39:37]);
        end

        // R9 status capture layout
        c = 11'b101_0110_1001;
        e = 9'h0C0;
        set_hdr({3'd1, 4'd2, 4'd3, 2'd1, 4'd7, 3'd3, 4'd5}, e, c);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        @(negedge clk);
        chk("R9 capture match", 16'(match_pulse), 16'b0011);
        rd("R9 byte0", 4'd0, {3'b0, e[0], 4'd3});
        rd("R9 byte1", 4'd1, {3'b0, e[1], 4'd2});
        rd("R9 byte2", 4'd2, {3'b0, e[2], 4'd5});
        rd("R9 byte3", 4'd3, {3'b0, e[3], c[0], 3'd3});
        rd("R9 byte4", 4'd4, {3'b0, e[4], 4'd7});
        rd("R9 byte5", 4'd5, {3'b0, e[5], c[2], c[1], 2'd1});
        rd("R9 byte6", 4'd6, {3'b0, e[6], c[6:3]});
        rd("R9 byte7", 4'd7, {3'b0, e[7], c[10:7]});
        rd("R10 found byte8", 4'd8, 8'h01);
        rd("R10 pblf cleared", 4'd9, 8'h00);
        rd("R10 idx12", 4'd12, 8'h00);
        @(negedge clk);

        // R9 non-matching header leaves row
        run_hdr("R9 no match", {3'd7, 4'd1, 4'd1, 2'd0, 4'd0, 3'd0, 4'd0}, 9'h0, 4'b0000, 1'b0, 3'd0);
        rd("R9 row unchanged", 4'd0, 8'h03);
        rd("R9 row unchanged mag", 4'd8, 8'h01);

        // R4 / R8: hold slot 0, slot 1 (bank 1) wins
        cfg(2'd0, 1'b0, 3'd0);
        wr(5'h11);
        run_hdr("R4 held slot0", {3'd1, 4'd2, 4'd3, 2'd0, 4'd0, 3'd0, 4'd5}, 9'h0, 4'b0010, 1'b1, 3'b101);

        // R2 wrap: column 6 then column 0 of slot 2, bank 1
        cfg(2'd2, 1'b1, 3'd6);
        wr(5'h00); wr(5'h1D);
        run_hdr("R2 wrap mag5", {3'd5, 4'd0, 4'd0, 2'd0, 4'd0, 3'd0, 4'd0}, 9'h0, 4'b0100, 1'b1, 3'b110);
        run_hdr("R2 old mag4 gone", {3'd4, 4'd0, 4'd0, 2'd0, 4'd0, 3'd0, 4'd0}, 9'h0, 4'b0000, 1'b0, 3'd0);

        // R7 back-to-back headers
        set_hdr({3'd1, 4'd2, 4'd3, 2'd0, 4'd0, 3'd0, 4'd5}, 9'h0, 11'd0);
        hdr_valid = 1'b1;
        @(negedge clk);
        set_hdr({3'd5, 4'd9, 4'd9, 2'd0, 4'd0, 3'd0, 4'd0}, 9'h0, 11'd0);
        @(negedge clk);
        hdr_valid = 1'b0;
        chk("R7 first pulse", 16'(match_pulse), 16'b0010);
        @(negedge clk);
        chk("R7 second pulse", 16'(match_pulse), 16'b0100);
        @(negedge clk);
        chk("R7 pulses end", 16'(match_pulse), 16'h0);

        // R11 write on the compare edge
        cfg(2'd2, 1'b1, 3'd0);
        set_hdr({3'd5, 4'd0, 4'd0, 2'd0, 4'd0, 3'd0, 4'd0}, 9'h0, 11'd0);
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        dat_wr = 1'b1; dat = 5'h1E;
        @(negedge clk);
        dat_wr = 1'b0;
        chk("R11 old entry used", 16'(match_pulse), 16'b0100);
        rd("R10 write with capture keeps pblf", 4'd9, 8'h20);
        @(negedge clk);
        run_hdr("R11 new entry mag5", {3'd5, 4'd0, 4'd0, 2'd0, 4'd0, 3'd0, 4'd0}, 9'h0, 4'b0000, 1'b0, 3'd0);
        run_hdr("R11 new entry mag6", {3'd6, 4'd0, 4'd0, 2'd0, 4'd0, 3'd0, 4'd0}, 9'h0, 4'b0100, 1'b1, 3'b110);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule